// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Interrupt and Reset Stages

This block is a two-stage watchdog controlled by a single 32-bit control word at one bus offset. It counts cycles of its own clock (the 25 MHz reference clock in the target system) through a four-way prescaler. Once a selectable number of prescaled ticks has gone by, it raises a sticky interrupt flag. If interrupts are enabled, the interrupt output follows that flag. If software does not respond, a further fixed number of prescaled ticks ends in a one-cycle reset request, provided reset is enabled.

Software arms the timer by setting the run bit and writing a one to the self-clearing restart bit. It services the timer by restarting it. It can pause counting by clearing the run bit, and counting then resumes from the same point. Both flags are cleared by writing ones to them. When the block issues its own reset request, it reloads its control word to the reset value but keeps the reset flag set. Software can therefore see, after the system reset, that the watchdog caused it. Only the power-on reset input clears that flag.

Top module: `wdog_prescaled`

## Requirements
- R1: The control word is read and written at offset 0x1C. Any other address reads 0. The field positions are: bits 11:10 prescaler select, bit 7 run, bit 6 interrupt enable, bits 5:4 interval select, bit 3 interrupt flag, bit 2 reset flag, bit 1 reset enable, bit 0 restart. All other bits, and the restart bit, read 0.
- R2: Prescaler select s divides the clock by 2^DIV_LOG2_s. The defaults give 1, 256, 2048 and 65536. One prescaled tick occurs after every D running cycles.
- R3: The interrupt flag (bit 3) sets on the clock edge that completes tick 2^(BASE_EXP + EXP_STEP*sel) after a restart, and no earlier. The defaults give 2^(14+2*sel).
- R4: The interrupt flag sets whether or not interrupt enable is set. The flag stays set until it is cleared. The interrupt output is high exactly when the flag and interrupt enable (bit 6) are both 1.
- R5: When reset enable (bit 1) is set, a reset request pulse lasting exactly one cycle follows RST_TICKS prescaled ticks (default 1024) after the interrupt point, whatever the value of interrupt enable.
- R6: When reset enable is clear, no reset request is issued and the reset flag stays 0, however long the count runs.
- R7: In the cycle the reset request is high, the control word reads prescaler select 1 with the reset flag set and every other bit 0 (value 0x404).
- R8: Writing 1 to bit 3 clears the interrupt flag, and writing 1 to bit 2 clears the reset flag. Writing 0 to either bit leaves it unchanged.
- R9: Writing 1 to the restart bit (bit 0) clears the prescaler and the tick count, so the full interval starts again from that edge.
- R10: While the run bit is 0 the count is frozen. Setting run again resumes from the remaining count and does not start over.
- R11: After power-on reset the control word reads 0x400 (prescaler select 1, all other bits 0, including the reset flag). The interrupt and reset request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also the bus clock |
| rst_n | input | 1 | Active-low power-on reset; clears everything including the reset flag |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| wdt_irq | output | 1 | Interrupt request, level |
| wdt_rst_req | output | 1 | System reset request, one-cycle pulse |

## Verification
The main function is tried with each prescaler setting and with several interval settings. Sampling one cycle before and exactly at the computed edge separates an off-by-one count from a correct one. Runs with interrupt enable off and reset enable off show that the flag and the reset stage are independent of the enables. A pause in the middle of a count and a repeated restart show that the first freezes the count and the second resets it. A behavioural model tracks the expected state in every cycle, so any stray pulse or flag change between these points is also caught.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // Bit positions of the control word; software decodes these.
   localparam int unsigned BIT_DIV_LO  = 10;
   localparam int unsigned BIT_RUN     = 7;
   localparam int unsigned BIT_IRQ_EN  = 6;
   localparam int unsigned BIT_SPAN_LO = 4;
   localparam int unsigned BIT_IRQ_FLG = 3;
   localparam int unsigned BIT_RST_FLG = 2;
   localparam int unsigned BIT_RST_EN  = 1;
   localparam int unsigned BIT_RESTART = 0;

   localparam logic [1:0] DIV_SEL_AT_RESET = 2'd1;

   typedef struct packed {
      logic [1:0] div_sel;
      logic       run;
      logic       irq_en;
      logic [1:0] span_sel;
      logic       irq_flag;
      logic       rst_flag;
      logic       rst_en;
   } wdog_ctl_t;

   function automatic wdog_ctl_t ctl_default(input logic keep_rst_flag);
      wdog_ctl_t c;
      c          = '0;
      c.div_sel  = DIV_SEL_AT_RESET;
      c.rst_flag = keep_rst_flag;
      return c;
   endfunction

   function automatic logic [31:0] pack_ctl(input wdog_ctl_t c);
      logic [31:0] w;
      w = '0;
      w[BIT_DIV_LO +: 2]  = c.div_sel;
      w[BIT_RUN]          = c.run;
      w[BIT_IRQ_EN]       = c.irq_en;
      w[BIT_SPAN_LO +: 2] = c.span_sel;
      w[BIT_IRQ_FLG]      = c.irq_flag;
      w[BIT_RST_FLG]      = c.rst_flag;
      w[BIT_RST_EN]       = c.rst_en;
      return w;
   endfunction

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
   parameter int unsigned PRE_W    = 16,
   parameter logic [31:0] DIV_LOG2 = {8'd16, 8'd11, 8'd8, 8'd0}
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       clear,
   input  logic [1:0] sel,
   output logic       tick
);

   logic [PRE_W-1:0] term [4];
   logic [PRE_W-1:0] cnt_q;
   logic             at_end;

   for (genvar g = 0; g < 4; g++) begin : g_term
      localparam int unsigned SH = int'(DIV_LOG2[g*8 +: 8]);
      if (SH > PRE_W) begin : g_bad
         $error("prescaler shift wider than counter");
      end
      assign term[g] = PRE_W'((64'd1 << SH) - 64'd1);
   end

   // >= rather than == so a switch to a shorter divisor never wraps the counter.
   assign at_end = (cnt_q >= term[sel]);
   assign tick   = run & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clear)  cnt_q <= '0;
      else if (run)    cnt_q <= at_end ? '0 : cnt_q + 1'b1;
   end

   // R10: with counting stopped the divider phase is preserved
   p_pre_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_span_counter.sv
module wdog_span_counter #(
   parameter int unsigned CNT_W     = 22,
   parameter int unsigned BASE_EXP  = 14,
   parameter int unsigned EXP_STEP  = 2,
   parameter int unsigned RST_TICKS = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       restart,
   input  logic [1:0] span_sel,
   input  logic       rst_en,
   output logic       irq_hit,
   output logic       rst_hit
);

   logic [CNT_W-1:0] span_tab [4];
   logic [CNT_W-1:0] span, limit, cnt_q, cnt_nx;
   logic             saturated, adv;

   for (genvar g = 0; g < 4; g++) begin : g_span
      assign span_tab[g] = CNT_W'(1) << (BASE_EXP + EXP_STEP * g);
   end

   assign span      = span_tab[span_sel];
   assign limit     = span + CNT_W'(RST_TICKS);
   assign saturated = (cnt_q >= limit);
   assign adv       = tick & ~saturated;
   assign cnt_nx    = cnt_q + 1'b1;
   assign irq_hit   = adv & ~restart & (cnt_nx == span);
   assign rst_hit   = adv & ~restart & rst_en & (cnt_nx == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (restart || rst_hit)  cnt_q <= '0;
      else if (adv)                 cnt_q <= cnt_nx;
   end

   // R10: no tick, no restart -> the tick count holds
   p_cnt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !restart) |=> $stable(cnt_q));

   // R5: the reset stage only ends after the interrupt point has passed
   p_rst_after_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_hit |-> (cnt_q >= span));

   // R9: a restart returns the count to zero
   p_restart_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0));

endmodule

// File: rtl/wdog_ctl_reg.sv
module wdog_ctl_reg
   import wdog_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   input  logic        irq_hit,
   input  logic        rst_hit,
   output wdog_ctl_t   ctl_o
);

   wdog_ctl_t ctl_q, ctl_d;
   logic      unused_wbits;

   assign unused_wbits = ^{wr_data[31:12], wr_data[9:8], wr_data[BIT_RESTART]};

   always_comb begin
      ctl_d = ctl_q;
      if (rst_hit) begin
         ctl_d = ctl_default(1'b1);
      end else if (wr_en) begin
         ctl_d.div_sel  = wr_data[BIT_DIV_LO +: 2];
         ctl_d.run      = wr_data[BIT_RUN];
         ctl_d.irq_en   = wr_data[BIT_IRQ_EN];
         ctl_d.span_sel = wr_data[BIT_SPAN_LO +: 2];
         ctl_d.rst_en   = wr_data[BIT_RST_EN];
         ctl_d.irq_flag = (ctl_q.irq_flag & ~wr_data[BIT_IRQ_FLG]) | irq_hit;
         ctl_d.rst_flag = ctl_q.rst_flag & ~wr_data[BIT_RST_FLG];
      end else begin
         ctl_d.irq_flag = ctl_q.irq_flag | irq_hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= ctl_default(1'b0);
      else        ctl_q <= ctl_d;
   end

   assign ctl_o = ctl_q;

   // R8: writing one to the interrupt flag clears it
   p_irq_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[BIT_IRQ_FLG] && !irq_hit && !rst_hit) |=> !ctl_q.irq_flag);

   // R4: the flag is sticky until cleared
   p_irq_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.irq_flag && !(wr_en && wr_data[BIT_IRQ_FLG]) && !rst_hit) |=> ctl_q.irq_flag);

   // R7: the watchdog's own reset leaves only select 1 and the reset flag
   p_self_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_hit |=> (ctl_q == ctl_default(1'b1)));

endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled
   import wdog_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned REG_OFFSET = 'h1C,
   parameter int unsigned BASE_EXP   = 14,
   parameter int unsigned EXP_STEP   = 2,
   parameter int unsigned RST_TICKS  = 1024,
   parameter int unsigned DIV_LOG2_0 = 0,
   parameter int unsigned DIV_LOG2_1 = 8,
   parameter int unsigned DIV_LOG2_2 = 11,
   parameter int unsigned DIV_LOG2_3 = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              wdt_irq,
   output logic              wdt_rst_req
);

   localparam int unsigned MAX_EXP  = BASE_EXP + 3 * EXP_STEP;
   localparam int unsigned CNT_W    = MAX_EXP + 2;
   localparam int unsigned MAX_DIV  = max4(DIV_LOG2_0, DIV_LOG2_1, DIV_LOG2_2, DIV_LOG2_3);
   localparam int unsigned PRE_W    = (MAX_DIV < 1) ? 1 : MAX_DIV;
   localparam logic [31:0] DIV_PACK = {8'(DIV_LOG2_3), 8'(DIV_LOG2_2),
                                       8'(DIV_LOG2_1), 8'(DIV_LOG2_0)};

   if (MAX_EXP > 30) begin : g_chk_exp
      $error("interval exponent too large");
   end
   if (MAX_DIV > 30) begin : g_chk_div
      $error("prescaler shift too large");
   end
   if (RST_TICKS < 1 || RST_TICKS > (1 << MAX_EXP)) begin : g_chk_rst
      $error("reset stage length out of range");
   end
   if ((REG_OFFSET % 4) != 0 || REG_OFFSET >= (1 << ADDR_W)) begin : g_chk_off
      $error("register offset unaligned or outside the address range");
   end

   wdog_ctl_t ctl;
   logic      reg_sel, wr_hit, restart, tick, irq_hit, rst_hit, rst_req_q;

   assign reg_sel = (bus_addr == ADDR_W'(REG_OFFSET));
   assign wr_hit  = bus_wr & reg_sel;
   assign restart = wr_hit & bus_wdata[BIT_RESTART];

   wdog_prescaler #(
      .PRE_W    (PRE_W),
      .DIV_LOG2 (DIV_PACK)
   ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ctl.run),
      .clear (restart | rst_hit),
      .sel   (ctl.div_sel),
      .tick  (tick)
   );

   wdog_span_counter #(
      .CNT_W     (CNT_W),
      .BASE_EXP  (BASE_EXP),
      .EXP_STEP  (EXP_STEP),
      .RST_TICKS (RST_TICKS)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .restart  (restart),
      .span_sel (ctl.span_sel),
      .rst_en   (ctl.rst_en),
      .irq_hit  (irq_hit),
      .rst_hit  (rst_hit)
   );

   wdog_ctl_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_hit),
      .wr_data (bus_wdata),
      .irq_hit (irq_hit),
      .rst_hit (rst_hit),
      .ctl_o   (ctl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_req_q <= 1'b0;
      else        rst_req_q <= rst_hit;
   end

   assign bus_rdata   = reg_sel ? pack_ctl(ctl) : 32'd0;
   assign wdt_irq     = ctl.irq_flag & ctl.irq_en;
   assign wdt_rst_req = rst_req_q;

   // R5: the reset request lasts one cycle
   p_rst_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_req |=> !wdt_rst_req);

   // R6: no reset request unless reset was enabled at the firing edge
   p_rst_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_req |-> $past(ctl.rst_en));

   // R7: the reset flag is visible while the request is high
   p_rflag_with_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_req |-> ctl.rst_flag);

endmodule

// File: tb/wdog_prescaled_bench.sv
module wdog_prescaled_bench;

   localparam int OFF  = 'h1C;
   localparam int BEXP = 3;
   localparam int RSTT = 6;
   localparam logic [31:0] W_RUN = 32'h80, W_IE = 32'h40, W_IF = 32'h08,
                           W_RF = 32'h04, W_RE = 32'h02, W_GO = 32'h01;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = 12'(OFF);
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wdt_irq, wdt_rst_req;

   int    n_checks = 0;
   int    n_fails  = 0;
   string phase    = "R11";

   always #10 clk = ~clk;

   wdog_prescaled #(
      .ADDR_W (12), .REG_OFFSET (OFF), .BASE_EXP (BEXP), .EXP_STEP (1),
      .RST_TICKS (RSTT), .DIV_LOG2_0 (0), .DIV_LOG2_1 (1),
      .DIV_LOG2_2 (2), .DIV_LOG2_3 (3)
   ) u_wdog_prescaled (
      .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
      .wdt_irq (wdt_irq), .wdt_rst_req (wdt_rst_req)
   );

   // ---------------- behavioural reference model ----------------
   int m_div, m_run, m_ie, m_span, m_if, m_rf, m_re, m_pre, m_cnt, m_req;

   function automatic int word_of();
      return (m_div << 10) | (m_run << 7) | (m_ie << 6) | (m_span << 4) |
             (m_if << 3) | (m_rf << 2) | (m_re << 1);
   endfunction

   always @(posedge clk) begin
      int tick, hit, fire, span, lim, go, wr;
      if (!rst_n) begin
         m_div = 1; m_run = 0; m_ie = 0; m_span = 0; m_if = 0; m_rf = 0;
         m_re = 0; m_pre = 0; m_cnt = 0; m_req = 0;
      end else begin
         tick = 0; hit = 0; fire = 0;
         wr   = (bus_wr && bus_addr == 12'(OFF)) ? 1 : 0;
         go   = (wr != 0 && bus_wdata[0]) ? 1 : 0;
         span = 1 << (BEXP + m_span);
         lim  = span + RSTT;
         if (m_run != 0) begin
            if (m_pre + 1 >= (1 << m_div)) begin tick = 1; m_pre = 0; end
            else m_pre = m_pre + 1;
         end
         if (tick != 0 && m_cnt < lim && go == 0) begin
            m_cnt = m_cnt + 1;
            if (m_cnt == span) hit = 1;
            if (m_cnt == lim && m_re != 0) fire = 1;
         end
         if (go != 0 || fire != 0) begin m_cnt = 0; m_pre = 0; end
         if (fire != 0) begin
            m_div = 1; m_run = 0; m_ie = 0; m_span = 0; m_if = 0; m_rf = 1; m_re = 0;
         end else if (wr != 0) begin
            m_div  = int'(bus_wdata[11:10]);
            m_run  = int'(bus_wdata[7]);
            m_ie   = int'(bus_wdata[6]);
            m_span = int'(bus_wdata[5:4]);
            m_re   = int'(bus_wdata[1]);
            m_if   = ((m_if != 0 && !bus_wdata[3]) || hit != 0) ? 1 : 0;
            m_rf   = (m_rf != 0 && !bus_wdata[2]) ? 1 : 0;
         end else if (hit != 0) begin
            m_if = 1;
         end
         m_req = fire;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      logic [31:0] exp_w;
      #2;
      if (rst_n) begin
         exp_w = (bus_addr == 12'(OFF)) ? 32'(word_of()) : 32'd0;
         n_checks++;
         if (bus_rdata !== exp_w || wdt_irq !== ((m_if & m_ie) != 0) ||
             wdt_rst_req !== (m_req != 0)) begin
            n_fails++;
            $display("FAIL %s model: rdata=%h irq=%b req=%b expected rdata=%h irq=%0d req=%0d",
                     phase, bus_rdata, wdt_irq, wdt_rst_req, exp_w, m_if & m_ie, m_req);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] dv(input int s); return 32'(s) << 10; endfunction
   function automatic logic [31:0] sp(input int s); return 32'(s) << 4;  endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", n_checks + 1 - n_fails, n_checks + 1);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R11: power-on value
      chk("R11 reset word", bus_rdata, 32'h400);
      chk("R11 outputs low", {30'd0, wdt_irq, wdt_rst_req}, 32'd0);

      // R1: other addresses read zero
      phase = "R1";
      bus_addr = 12'h018; step(1);
      chk("R1 other address", bus_rdata, 32'd0);
      bus_addr = 12'(OFF); step(1);

      // R3/R4: interval 8 ticks, divide by 1
      phase = "R3";
      wr(W_RUN | W_IE | W_GO);
      step(7);
      chk("R3 flag not early", {31'd0, bus_rdata[3]}, 32'd0);
      step(1);
      chk("R3 flag at interval", {31'd0, bus_rdata[3]}, 32'd1);
      chk("R4 irq with enable", {31'd0, wdt_irq}, 32'd1);

      // R8 then R6: clear the flag, run past the reset point without reset enable
      phase = "R6";
      wr(W_RUN | W_IE | W_IF);
      chk("R8 flag cleared", {31'd0, bus_rdata[3]}, 32'd0);
      step(40);
      chk("R6 no reset request", {31'd0, wdt_rst_req}, 32'd0);
      chk("R6 reset flag stays 0", {31'd0, bus_rdata[2]}, 32'd0);

      // R2/R4: divide by 4, interval 16 -> 64 cycles, interrupt disabled
      phase = "R2";
      wr(dv(2) | sp(1) | W_RUN | W_GO);
      step(63);
      chk("R2 flag not early /4", {31'd0, bus_rdata[3]}, 32'd0);
      step(1);
      chk("R4 flag without enable", {31'd0, bus_rdata[3]}, 32'd1);
      chk("R4 irq masked", {31'd0, wdt_irq}, 32'd0);
      wr(dv(2) | sp(1) | W_RUN | W_IE);
      chk("R4 irq after enable", {31'd0, wdt_irq}, 32'd1);

      // R10: pause after 5 ticks, resume, 3 more ticks to reach 8
      phase = "R10";
      wr(W_RUN | W_GO | W_IF);
      step(4);
      wr(32'd0);
      step(20);
      chk("R10 frozen while paused", {31'd0, bus_rdata[3]}, 32'd0);
      wr(W_RUN);
      step(2);
      chk("R10 resumed not early", {31'd0, bus_rdata[3]}, 32'd0);
      step(1);
      chk("R10 resumed from remaining count", {31'd0, bus_rdata[3]}, 32'd1);

      // R5/R7: divide by 2, interval 8, reset stage 6 -> pulse after 28 cycles
      phase = "R5";
      wr(dv(1) | W_RUN | W_RE | W_GO | W_IF);
      step(27);
      chk("R5 no request early", {31'd0, wdt_rst_req}, 32'd0);
      step(1);
      chk("R5 request issued", {31'd0, wdt_rst_req}, 32'd1);
      chk("R7 word after self reset", bus_rdata, 32'h404);
      step(1);
      chk("R5 single-cycle pulse", {31'd0, wdt_rst_req}, 32'd0);

      // R8: clear reset flag by writing one
      phase = "R8";
      wr(dv(1) | W_RF);
      chk("R8 reset flag cleared", bus_rdata, 32'h400);

      // R9: restart mid-count restarts the full interval
      phase = "R9";
      wr(W_RUN | W_GO);
      step(6);
      wr(W_RUN | W_GO);
      step(7);
      chk("R9 restart delays flag", {31'd0, bus_rdata[3]}, 32'd0);
      step(1);
      chk("R9 flag after full interval", {31'd0, bus_rdata[3]}, 32'd1);

      // R1: field readback, restart reads zero
      phase = "R1";
      wr(dv(3) | sp(3) | W_IE | W_RE | W_GO | W_IF);
      chk("R1 field readback", bus_rdata, 32'h0C72);

      // R2: divide by 8, interval 8 -> 64 cycles
      phase = "R2";
      wr(dv(3) | W_RUN | W_GO | W_IF);
      step(63);
      chk("R2 flag not early /8", {31'd0, bus_rdata[3]}, 32'd0);
      step(1);
      chk("R2 flag at 64 cycles", {31'd0, bus_rdata[3]}, 32'd1);

      // R11: power-on reset clears a set reset flag
      phase = "R11";
      wr(W_RUN | W_RE | W_GO | W_IF);
      step(14);
      chk("R7 self reset again", bus_rdata, 32'h404);
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
      step(1);
      chk("R11 power-on clears reset flag", bus_rdata, 32'h400);

      step(2);
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end

endmodule